// File: doc/BRIEF.md
# Chip-Select Output Controller

This block owns the chip-select lines of a serial peripheral master. Software reaches it through a simple register write port and a combinational read port. A configuration register holds two things for each line: a mark saying that the line serves as a chip-select, and an inversion control. A force register has one half that raises a line's stored bit and another half that lowers it. Writing a 1 acts on the line, and writing a 0 leaves it alone, so no read-modify-write is ever needed. A status register returns the stored bits.

Each pin is its stored bit exclusive-ORed with that line's inversion bit. Selecting a device means clearing its stored bit. With inversion off the line is therefore active low, and with inversion on it is active high. After reset every stored bit is 1 and every control bit is 0, so no device is selected. The mark bits are passed out unchanged to the pad logic that sits next to this block.

Top module: `csOutCtrl`

## Requirements
- R1: After reset every stored bit is 1, the configuration register is 0, every pin is 1, and status reads 0x00FF.
- R2: A write to the force register (address 1) with bit n (0..7) set and bit 8+n clear drives stored bit n to 0 on the next clock edge.
- R3: A force write with bit 8+n set drives stored bit n to 1 on the next clock edge.
- R4: A stored bit whose set and clear force bits are both 0, or that sees no force write, keeps its value.
- R5: When a single force write has both bit 8+n and bit n set, stored bit n becomes 1.
- R6: Pin n equals stored bit n XOR inversion bit n, where inversion bits are bits 7:0 of the configuration register (address 0).
- R7: The mark bits are bits 15:8 of the configuration register and appear on csMark. The configuration register reads back at address 0 as {mark, inversion}.
- R8: A read at address 2 returns the stored bits in bits 7:0 and zeros in bits 15:8.
- R9: A configuration write, a write to an unmapped address (3), and bus activity while wrEn is low all leave the stored bits unchanged.
- R10: A force write of 0xFF00 sets every stored bit to 1, so every line goes to its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Write address: 0 configuration, 1 force |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address: 0 configuration, 2 status |
| rdData | output | 16 | Read data, combinational |
| csPin | output | 8 | Chip-select pin levels |
| csMark | output | 8 | Per-line chip-select mark for the pad logic |

## Verification
A wrong stored bit shows on the matching pin and in the status word one cycle after the write that caused it, so the bench compares both after every write. A wrong inversion or mark bit shows the same way on csPin, csMark and the configuration readback. The sweep covers every line with every set/clear combination, and every inversion pattern over a fixed stored pattern. An error in a single line therefore cannot hide behind the others.

// File: rtl/csOutCtrlPkg.sv
package csOutCtrlPkg;

  // write strobes produced by the decoder
  typedef struct packed {
    logic ctrlWr;
    logic forceWr;
  } csStrobeT;

  // read source selection
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_CTRL   = 2'd1,
    RD_STATUS = 2'd2
  } csRdSelT;

endpackage

// File: rtl/csCtrlDecode.sv
module csCtrlDecode
  import csOutCtrlPkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int CTRL_ADDR   = 0,
  parameter int FORCE_ADDR  = 1,
  parameter int STATUS_ADDR = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output csStrobeT          strobe,
  output csRdSelT           rdSel
);

  localparam logic [ADDR_W-1:0] CtrlA   = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] ForceA  = ADDR_W'(FORCE_ADDR);
  localparam logic [ADDR_W-1:0] StatusA = ADDR_W'(STATUS_ADDR);

  always_comb begin
    strobe.ctrlWr  = wrEn && (wrAddr == CtrlA);
    strobe.forceWr = wrEn && (wrAddr == ForceA);
  end

  always_comb begin
    if (rdAddr == CtrlA)        rdSel = RD_CTRL;
    else if (rdAddr == StatusA) rdSel = RD_STATUS;
    else                        rdSel = RD_NONE;
  end

endmodule

// File: rtl/csLineDatapath.sv
module csLineDatapath
  import csOutCtrlPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  csStrobeT       strobe,
  input  logic [2*N-1:0] wrData,
  input  csRdSelT        rdSel,
  output logic [N-1:0]   storedBits,
  output logic [N-1:0]   invBits,
  output logic [N-1:0]   csMark,
  output logic [N-1:0]   csPin,
  output logic [2*N-1:0] rdData
);

  localparam int DW = 2 * N;

  for (genvar i = 0; i < N; i++) begin : gLine
    logic bitQ;
    logic invQ;
    logic markQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        bitQ  <= 1'b1;
        invQ  <= 1'b0;
        markQ <= 1'b0;
      end else begin
        // set half wins over clear half
        if (strobe.forceWr) begin
          if (wrData[N+i])   bitQ <= 1'b1;
          else if (wrData[i]) bitQ <= 1'b0;
        end
        if (strobe.ctrlWr) begin
          invQ  <= wrData[i];
          markQ <= wrData[N+i];
        end
      end
    end

    assign storedBits[i] = bitQ;
    assign invBits[i]    = invQ;
    assign csMark[i]     = markQ;
    assign csPin[i]      = bitQ ^ invQ;
  end

  always_comb begin
    unique case (rdSel)
      RD_CTRL:   rdData = {csMark, invBits};
      RD_STATUS: rdData = {{N{1'b0}}, storedBits};
      default:   rdData = {DW{1'b0}};
    endcase
  end

endmodule

// File: rtl/csOutCtrl.sv
module csOutCtrl
  import csOutCtrlPkg::*;
#(
  parameter int N           = 8,
  parameter int ADDR_W      = 2,
  parameter int CTRL_ADDR   = 0,
  parameter int FORCE_ADDR  = 1,
  parameter int STATUS_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2*N-1:0]    wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [2*N-1:0]    rdData,
  output logic [N-1:0]      csPin,
  output logic [N-1:0]      csMark
);

  csStrobeT     strobe;
  csRdSelT      rdSel;
  logic [N-1:0] storedBits;
  logic [N-1:0] invBits;

  csCtrlDecode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .FORCE_ADDR(FORCE_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) decode_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .strobe(strobe), .rdSel(rdSel)
  );

  csLineDatapath #(.N(N)) data_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .rdSel(rdSel), .storedBits(storedBits), .invBits(invBits),
    .csMark(csMark), .csPin(csPin), .rdData(rdData)
  );

endmodule

// File: rtl/csOutCtrlChk.sv
module csOutCtrlChk #(
  parameter int N           = 8,
  parameter int ADDR_W      = 2,
  parameter int CTRL_ADDR   = 0,
  parameter int FORCE_ADDR  = 1,
  parameter int STATUS_ADDR = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [2*N-1:0]    wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [2*N-1:0]    rdData,
  input logic [N-1:0]      csMark,
  input logic [N-1:0]      storedBits,
  input logic [N-1:0]      invBits
);

  logic          fWr, cWr;
  logic [N-1:0]  setH, clrH;
  assign fWr  = wrEn && (wrAddr == ADDR_W'(FORCE_ADDR));
  assign cWr  = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
  assign setH = wrData[2*N-1:N];
  assign clrH = wrData[N-1:0];

  // R1: reset leaves all lines deselected and control cleared
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (storedBits == {N{1'b1}}) && (invBits == '0) && (csMark == '0));

  // R2: a clear without its set lowers the bit
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    fWr |=> (storedBits & ($past(clrH) & ~$past(setH))) == '0);

  // R3 and R5: a set raises the bit, even alongside a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    fWr |=> (storedBits & $past(setH)) == $past(setH));

  // R4 and R9: no force write means the stored bits hold
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !fWr |=> $stable(storedBits));

  // R7: configuration write lands on the mark outputs
  p_mark_r7: assert property (@(posedge clk) disable iff (rst)
    cWr |=> csMark == $past(setH));

  // R8: status read reflects the stored bits
  p_status_r8: assert property (@(posedge clk) disable iff (rst)
    (rdAddr == ADDR_W'(STATUS_ADDR)) |-> rdData == {{N{1'b0}}, storedBits});

endmodule

bind csOutCtrl csOutCtrlChk #(
  .N(N), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
  .FORCE_ADDR(FORCE_ADDR), .STATUS_ADDR(STATUS_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .csMark(csMark),
  .storedBits(storedBits), .invBits(invBits)
);

// File: tb/csOutCtrl_tb_top.sv
module csOutCtrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [2*N-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [2*N-1:0] rdData;
  logic [N-1:0]  csPin, csMark;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [N-1:0] mStored, mInv, mMark;

  always #(CLK_PERIOD/2) clk = ~clk;

  csOutCtrl dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .csPin(csPin), .csMark(csMark)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOuts(input string tag);
    chk(tag, 32'(csPin), 32'(mStored ^ mInv));
    chk(tag, 32'(csMark), 32'(mMark));
    rdAddr = 2'd2; #1;
    chk(tag, 32'(rdData), 32'({8'h00, mStored}));
    rdAddr = 2'd0; #1;
    chk(tag, 32'(rdData), 32'({mMark, mInv}));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [2*N-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd1) mStored = (mStored & ~d[N-1:0]) | d[2*N-1:N];
    else if (a == 2'd0) begin mInv = d[N-1:0]; mMark = d[2*N-1:N]; end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mStored = '1; mInv = '0; mMark = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    doReset();
    checkOuts("R1");

    // every line, every set/clear combination
    for (int n = 0; n < N; n++) begin
      for (int c = 0; c < 4; c++) begin
        logic [2*N-1:0] d;
        d = '0;
        d[N+n] = c[1];
        d[n]   = c[0];
        wr(2'd1, d);
        case (c)
          0: checkOuts("R4");
          1: checkOuts("R2");
          2: checkOuts("R3");
          default: checkOuts("R5");
        endcase
        wr(2'd1, 16'h0000 | (16'h0001 << n));   // clear n
        checkOuts("R2");
        wr(2'd1, 16'h0003 << (2*N-2));          // set top two, touch nothing else
        checkOuts("R4");
      end
    end

    wr(2'd1, 16'h00FF);
    checkOuts("R2");
    wr(2'd1, 16'hFF00);
    checkOuts("R10");

    // stored pattern, then every inversion pattern
    wr(2'd1, 16'h3CC3);
    checkOuts("R3");
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, {8'(v) ^ 8'hA5, 8'(v)});
      checkOuts("R6 R7 R9");
    end

    // no write strobe: force data on the bus is ignored
    @(negedge clk);
    wrAddr = 2'd1; wrData = 16'h00FF; wrEn = 1'b0;
    @(negedge clk);
    checkOuts("R9");
    // unmapped address ignored
    wr(2'd3, 16'h00FF);
    checkOuts("R9");
    // status read at address 2 with upper byte zero
    rdAddr = 2'd2; #1;
    chk("R8", 32'(rdData[15:8]), 32'h0);
    rdAddr = 2'd0;

    // pseudo-random force traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr(2'd1, lfsr);
      checkOuts("R2 R3 R5");
    end

    // reset mid-run
    doReset();
    checkOuts("R1");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule